// File: doc/BRIEF.md
# System Exception Control Registers

This block holds the software-visible controls for the system exceptions of a microcontroller interrupt controller. It sits on a 32-bit register bus. Software uses it to:

- raise or withdraw the pending state of the non-maskable, deferred-service and tick-timer exceptions;
- move the vector table base;
- issue key-protected reset and group requests;
- enable the three fault handlers;
- pend any external interrupt by number.

Priority arbitration is done elsewhere. The arbiter feeds the current active and pending state into this block as input vectors. The block only turns register writes into one-cycle set or clear pulses toward the arbiter.

The status reads carry no stored state of their own. The control/state word and the handler status word are built each cycle from the arbiter's inputs. The only stored values are:

- the vector table base;
- the three fault-enable bits;
- the priority group field.

Reads are combinational on the address. Writes take effect on the clock edge where the write strobe is high. Bits 1:0 of the byte address are ignored.

Top module: `sysexc_regs`

## Requirements
- R1: A write to offset 0xD04 with bit 31 set produces a one-cycle `set_nmi` pulse in the cycle after the write.
- R2: At offset 0xD04, bit 28 gives a one-cycle `set_pendsv` pulse and bit 27 gives a one-cycle `clr_pendsv` pulse. When both bits are 1, only the set pulse appears.
- R3: At offset 0xD04, bit 26 gives a one-cycle `set_systick` pulse and bit 25 gives a one-cycle `clr_systick` pulse. When both bits are 1, only the set pulse appears.
- R4: A read of 0xD04 returns the following fields:
  - `act_vec` in bits 8:0;
  - `pend_vec` in bits 20:12;
  - bit 22 when any bit of `ext_pend` is set;
  - bit 11 when an external interrupt is active whose vector (index + 16) differs from `act_vec`;
  - bits 26, 28 and 31 equal to `systick_pnd`, `pendsv_pnd` and `nmi_pnd`.
- R5: A write to 0xD08 stores the data with bits 6:0 forced to zero. The stored value appears on `vtor` and is read back at 0xD08.
- R6: A read of 0xD0C always returns 0xFA050000. A write to 0xD0C acts only when bits 31:16 equal 0x05FA. It then pulses `clr_active_req` if bit 1 is set and `sysreset_req` if bit 2 is set, and it latches bits 10:8 into `prio_group`. A write with any other key changes nothing.
- R7: A read of 0xD24 returns the following fields:
  - active bits, from `sys_act[6:0]` = {tick, deferred, monitor, service call, usage, bus, memory}: memory in bit 0, bus in bit 1, usage in bit 3, service call in bit 7, monitor in bit 8, deferred in bit 10, tick in bit 11;
  - pending bits 15:12, equal to `sys_pnd[3:0]` = {service call, bus, memory, usage};
  - enable bits 18:16, equal to `fault_en`.
- R8: A write to 0xD24 changes only `fault_en` = {usage, bus, memory}, taken from data bits 18:16.
- R9: A write to 0xF00 pulses `ext_set` for one cycle with `ext_set_num` equal to data bits 8:0. This happens only when that number is below NIRQ; otherwise no pulse appears.
- R10: After reset, every pulse output is 0 and `vtor`, `fault_en` and `prio_group` are 0. Any other offset reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the address |
| act_vec | input | 9 | Currently active vector number |
| pend_vec | input | 9 | Highest pending vector number |
| ext_pend | input | NIRQ | Pending state of the external interrupts |
| ext_act | input | NIRQ | Active state of the external interrupts |
| nmi_pnd | input | 1 | Non-maskable exception pending |
| pendsv_pnd | input | 1 | Deferred service exception pending |
| systick_pnd | input | 1 | Tick timer exception pending |
| sys_act | input | 7 | Active state of the system handlers |
| sys_pnd | input | 4 | Pending state of the fault and service-call handlers |
| set_nmi | output | 1 | Pulse that sets non-maskable pending |
| set_pendsv | output | 1 | Pulse that sets deferred service pending |
| clr_pendsv | output | 1 | Pulse that clears deferred service pending |
| set_systick | output | 1 | Pulse that sets tick pending |
| clr_systick | output | 1 | Pulse that clears tick pending |
| ext_set | output | 1 | Pulse that sets an external interrupt pending |
| ext_set_num | output | 9 | Interrupt number for `ext_set` |
| vtor | output | 32 | Vector table base |
| fault_en | output | 3 | Fault handler enables {usage, bus, memory} |
| prio_group | output | 3 | Latched priority group field |
| sysreset_req | output | 1 | Pulse requesting system reset |
| clr_active_req | output | 1 | Pulse requesting a clear of active state |

## Verification
The bench drives both halves of each paired set/clear field at once. A design that let the clear win, or issued both pulses, would show a clear pulse with no set.

Trigger numbers exactly at NIRQ and at the 9-bit maximum must give no pulse. A number whose upper data bits are set beyond bit 8 must still fire on its low nine bits. A wrong compare or a wrong mask would fire or drop those pulses.

A wrong key is written after a good one. A design that ignored the key would change `prio_group` or pulse a request.

The "other external active" bit is exercised three ways:
- with only the current vector active, where a design missing the exclusion would set it;
- with a second external interrupt also active;
- while a non-external vector is active.

// File: rtl/sysexc_regs.sv
module sysexc_regs #(
  parameter int NIRQ = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [11:0]     bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [8:0]      act_vec,
  input  logic [8:0]      pend_vec,
  input  logic [NIRQ-1:0] ext_pend,
  input  logic [NIRQ-1:0] ext_act,
  input  logic            nmi_pnd,
  input  logic            pendsv_pnd,
  input  logic            systick_pnd,
  input  logic [6:0]      sys_act,
  input  logic [3:0]      sys_pnd,
  output logic            set_nmi,
  output logic            set_pendsv,
  output logic            clr_pendsv,
  output logic            set_systick,
  output logic            clr_systick,
  output logic            ext_set,
  output logic [8:0]      ext_set_num,
  output logic [31:0]     vtor,
  output logic [2:0]      fault_en,
  output logic [2:0]      prio_group,
  output logic            sysreset_req,
  output logic            clr_active_req
);
  localparam logic [9:0]  W_CTRL = 10'h341;
  localparam logic [9:0]  W_VTAB = 10'h342;
  localparam logic [9:0]  W_KEYR = 10'h343;
  localparam logic [9:0]  W_HND  = 10'h349;
  localparam logic [9:0]  W_TRIG = 10'h3C0;
  localparam logic [15:0] KEY_IN = 16'h05FA;
  localparam logic [31:0] KEY_RD = 32'hFA050000;

  logic [9:0] word;
  logic       wr_ctrl, wr_vtab, wr_keyr, wr_hnd, wr_trig, key_ok, trig_ok, other_act;
  wire        unused_addr = ^bus_addr[1:0];

  assign word    = bus_addr[11:2];
  assign wr_ctrl = bus_wr && word == W_CTRL;
  assign wr_vtab = bus_wr && word == W_VTAB;
  assign wr_keyr = bus_wr && word == W_KEYR && bus_wdata[31:16] == KEY_IN;
  assign wr_hnd  = bus_wr && word == W_HND;
  assign wr_trig = bus_wr && word == W_TRIG;
  assign key_ok  = wr_keyr;
  assign trig_ok = 32'(bus_wdata[8:0]) < NIRQ;

  always_comb begin
    other_act = 1'b0;
    for (int i = 0; i < NIRQ; i++)
      if (ext_act[i] && act_vec != 9'(i + 16)) other_act = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_nmi        <= 1'b0;
      set_pendsv     <= 1'b0;
      clr_pendsv     <= 1'b0;
      set_systick    <= 1'b0;
      clr_systick    <= 1'b0;
      ext_set        <= 1'b0;
      ext_set_num    <= '0;
      sysreset_req   <= 1'b0;
      clr_active_req <= 1'b0;
      vtor           <= '0;
      fault_en       <= '0;
      prio_group     <= '0;
    end else begin
      set_nmi        <= wr_ctrl && bus_wdata[31];
      set_pendsv     <= wr_ctrl && bus_wdata[28];
      clr_pendsv     <= wr_ctrl && !bus_wdata[28] && bus_wdata[27];
      set_systick    <= wr_ctrl && bus_wdata[26];
      clr_systick    <= wr_ctrl && !bus_wdata[26] && bus_wdata[25];
      ext_set        <= wr_trig && trig_ok;
      sysreset_req   <= key_ok && bus_wdata[2];
      clr_active_req <= key_ok && bus_wdata[1];
      if (wr_trig)  ext_set_num <= bus_wdata[8:0];
      if (wr_vtab)  vtor        <= {bus_wdata[31:7], 7'b0};
      if (wr_hnd)   fault_en    <= bus_wdata[18:16];
      if (key_ok)   prio_group  <= bus_wdata[10:8];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (word)
      W_CTRL: begin
        bus_rdata[8:0]   = act_vec;
        bus_rdata[11]    = other_act;
        bus_rdata[20:12] = pend_vec;
        bus_rdata[22]    = |ext_pend;
        bus_rdata[26]    = systick_pnd;
        bus_rdata[28]    = pendsv_pnd;
        bus_rdata[31]    = nmi_pnd;
      end
      W_VTAB: bus_rdata = vtor;
      W_KEYR: bus_rdata = KEY_RD;
      W_HND: begin
        bus_rdata[0]     = sys_act[0];
        bus_rdata[1]     = sys_act[1];
        bus_rdata[3]     = sys_act[2];
        bus_rdata[7]     = sys_act[3];
        bus_rdata[8]     = sys_act[4];
        bus_rdata[10]    = sys_act[5];
        bus_rdata[11]    = sys_act[6];
        bus_rdata[15:12] = sys_pnd;
        bus_rdata[18:16] = fault_en;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sysexc_regs_chk.sv
module sysexc_regs_chk #(
  parameter int NIRQ = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        set_nmi,
  input logic        set_pendsv,
  input logic        clr_pendsv,
  input logic        set_systick,
  input logic        clr_systick,
  input logic        ext_set,
  input logic [8:0]  ext_set_num,
  input logic [31:0] vtor,
  input logic        sysreset_req
);
  logic hit_ctrl, hit_vtab, hit_keyr;
  assign hit_ctrl = bus_addr[11:2] == 10'h341;
  assign hit_vtab = bus_addr[11:2] == 10'h342;
  assign hit_keyr = bus_addr[11:2] == 10'h343;

  AST_NMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    set_nmi |-> $past(bus_wr && hit_ctrl && bus_wdata[31])); // R1
  AST_PENDSV_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pendsv |-> !set_pendsv); // R2
  AST_SYSTICK_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_systick |-> !set_systick); // R3
  AST_VTAB_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_vtab) |=> vtor == {$past(bus_wdata[31:7]), 7'b0}); // R5
  AST_KEY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    sysreset_req |-> $past(bus_wr && hit_keyr && bus_wdata[31:16] == 16'h05FA && bus_wdata[2])); // R6
  AST_KEY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    hit_keyr |-> bus_rdata == 32'hFA050000); // R6
  AST_TRIG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_set |-> 32'(ext_set_num) < NIRQ); // R9
endmodule

bind sysexc_regs sysexc_regs_chk #(.NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .set_nmi(set_nmi),
  .set_pendsv(set_pendsv), .clr_pendsv(clr_pendsv), .set_systick(set_systick),
  .clr_systick(clr_systick), .ext_set(ext_set), .ext_set_num(ext_set_num),
  .vtor(vtor), .sysreset_req(sysreset_req)
);

// File: tb/test_sysexc_regs.sv
`timescale 1ns/1ps
module test_sysexc_regs;
  localparam int NIRQ = 64;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, vtor;
  logic [8:0] act_vec = '0, pend_vec = '0, ext_set_num;
  logic [NIRQ-1:0] ext_pend = '0, ext_act = '0;
  logic nmi_pnd = 0, pendsv_pnd = 0, systick_pnd = 0;
  logic [6:0] sys_act = '0;
  logic [3:0] sys_pnd = '0;
  logic set_nmi, set_pendsv, clr_pendsv, set_systick, clr_systick, ext_set;
  logic sysreset_req, clr_active_req;
  logic [2:0] fault_en, prio_group;
  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  sysexc_regs #(.NIRQ(NIRQ)) i_sysexc_regs (.*);

  typedef struct packed {
    logic [11:0] a;
    logic [31:0] d;
    logic [7:0]  p;   // {nmi, set_psv, clr_psv, set_tick, clr_tick, ext_set, rst_req, clr_act}
    logic [8:0]  n;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{12'hD04, 32'h8000_0000, 8'h80, 9'd0},   // R1
    '{12'hD04, 32'h1800_0000, 8'h40, 9'd0},   // R2 set wins
    '{12'hD04, 32'h0800_0000, 8'h20, 9'd0},   // R2 clear
    '{12'hD04, 32'h0600_0000, 8'h10, 9'd0},   // R3 set wins
    '{12'hD04, 32'h0200_0000, 8'h08, 9'd0},   // R3 clear
    '{12'hD04, 32'h9400_0000, 8'hD0, 9'd0},   // R1 R2 R3 together
    '{12'hF00, 32'h0000_003F, 8'h04, 9'd63},  // R9 top of range
    '{12'hF00, 32'h0000_0040, 8'h00, 9'd0},   // R9 equal to NIRQ
    '{12'hF00, 32'h0000_01FF, 8'h00, 9'd0},   // R9 max field
    '{12'hF00, 32'hFFFF_FE00, 8'h04, 9'd0},   // R9 upper bits ignored
    '{12'hD0C, 32'h05FA_0006, 8'h03, 9'd0},   // R6 good key
    '{12'hD0C, 32'h05FB_0006, 8'h00, 9'd0},   // R6 bad key
    '{12'hD00, 32'hFFFF_FFFF, 8'h00, 9'd0}    // R10 unmapped
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  function automatic logic [7:0] pulses();
    return {set_nmi, set_pendsv, clr_pendsv, set_systick, clr_systick, ext_set, sysreset_req, clr_active_req};
  endfunction

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1 check(req, bus_rdata, exp);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10 pulses at reset", 32'(pulses()), 32'h0);
    check("R10 vtor at reset", vtor, 32'h0);
    check("R10 enables at reset", {29'b0, fault_en}, 32'h0);
    check("R10 group at reset", {29'b0, prio_group}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      string tag;
      case (VECS[k].a)
        12'hD04: tag = "R1 R2 R3 pulses";
        12'hF00: tag = "R9 trigger";
        12'hD0C: tag = "R6 key";
        default: tag = "R10 unmapped";
      endcase
      wr(VECS[k].a, VECS[k].d);
      #1 check(tag, 32'(pulses()), 32'(VECS[k].p));
      if (VECS[k].p[2]) check("R9 number", 32'(ext_set_num), 32'(VECS[k].n));
      @(negedge clk);
      #1 check({tag, " one cycle"}, 32'(pulses()), 32'h0);
    end

    wr(12'hD08, 32'hFFFF_FFFF);
    #1 check("R5 vtor port", vtor, 32'hFFFF_FF80);
    rd("R5 vtor read", 12'hD08, 32'hFFFF_FF80);

    rd("R6 key read", 12'hD0C, 32'hFA05_0000);
    wr(12'hD0C, 32'h05FA_0700);
    #1 check("R6 group latched", {29'b0, prio_group}, 32'h7);
    wr(12'hD0C, 32'h1234_0300);
    #1 check("R6 group kept on bad key", {29'b0, prio_group}, 32'h7);

    wr(12'hD24, 32'hFFFF_FFFF);
    #1 check("R8 enables", {29'b0, fault_en}, 32'h7);
    rd("R8 only enables writable", 12'hD24, 32'h0007_0000);
    wr(12'hD24, 32'h0002_0000);
    #1 check("R8 bus enable only", {29'b0, fault_en}, 32'h2);
    sys_act = 7'h7F; sys_pnd = 4'hF;
    rd("R7 handler status", 12'hD24, 32'h0002_FD8B);
    sys_act = 7'b0000001; sys_pnd = 4'b0010;
    rd("R7 memory active and pending", 12'hD24, 32'h0002_2001);

    act_vec = 9'd20; pend_vec = 9'd17; ext_act = '0; ext_act[4] = 1'b1;
    rd("R4 only current active", 12'hD04, 32'h0001_1014);
    ext_act[9] = 1'b1;
    rd("R4 another active", 12'hD04, 32'h0001_1814);
    ext_pend[63] = 1'b1;
    rd("R4 external pending", 12'hD04, 32'h0041_1814);
    ext_pend = '0; ext_act = '0; ext_act[0] = 1'b1; act_vec = 9'd3; pend_vec = 9'd0;
    nmi_pnd = 1; pendsv_pnd = 1; systick_pnd = 1;
    rd("R4 system pending bits", 12'hD04, 32'h9400_0803);

    rd("R10 unmapped read", 12'hD00, 32'h0);
    rd("R10 unmapped read high", 12'hF04, 32'h0);
    rd("R10 vtor unchanged", 12'hD08, 32'hFFFF_FF80);
    finish_run();
  end
endmodule